// File: doc/BRIEF.md
# Concurrent Scan-Path Access Sequencer

This block runs a flat network of segment-insertion cells, each guarding one shift-register instrument, through a concurrent access schedule. At start only the cells are on the scan path. The first scan opens every cell whose instrument has work to do. Later scans serve all open instruments together. Each instrument leaves the path in the same scan that unloads its last result, so the path gets shorter as instruments finish.

The block drives the network directly. It provides a serial data bit, a shift enable, an update strobe and a capture strobe. Between two shift phases it leaves a fixed five-cycle update/capture gap. The clock is the test clock, so each clock cycle is one test-clock cycle.

Each instrument is configured with a register length and an access count. The length must be at least one. These settings must be held stable for the whole run. The block reports the current scan-path length and the state of each cell. It counts the access time split into three parts: instrument data bits, cell control bits and gap cycles. When the schedule completes, it gives a one-cycle done pulse.

Top module: `sib_scan_sequencer`

## Requirements
- R1: After reset, scan enable, serial data, update, capture and done are low, every cell is closed, the path length reads the cell count, and all four counters read zero.
- R2: A start pulse in idle begins the opening scan. This scan shifts one bit per cell, and the bit for slot s is 1 exactly when that slot's access count is nonzero.
- R3: Every shift phase lasts N + (sum of register lengths of the open slots) cycles. During the shift phase the path-length output shows that value.
- R4: Within a shift phase, bits leave in this order: slot N-1 control bit, then slot N-1 data (if open), then slot N-2 control bit and data, and so on down to slot 0 data. Each data segment is sent bit 0 first.
- R5: In the k-th data scan of an open slot (k = 1 … A), data bit j equals bit j of k, and bits above the counter width are 0. In the final unload scan the slot's data bits are all 0.
- R6: A slot opened by the opening scan stays open for exactly A+1 further scans. Its control bit is 1 while more than one scan remains and 0 in the last scan. Cell states change only on the cycle after the update strobe.
- R7: Each shift phase is followed by exactly 5 cycles with scan enable low. The update strobe is high in the 2nd of these cycles and the capture strobe in the 4th.
- R8: Done is high for exactly one cycle. It comes right after the gap of the scan that leaves no cell open, which is the opening scan itself when every access count is 0. Every cell is closed while done is high.
- R9: The total counter equals data cycles + control cycles + gap cycles. For lengths 3, 5, 4 and counts 5, 4, 10 the counters read 183, 87, 36 and 60.
- R10: A start pulse during a run is ignored. The bit stream and the counters are unaffected.
- R11: Start clears all counters, so they read 0 in the first shift cycle. After done they hold their final values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a schedule (honoured only when idle) |
| inst_len_i | input | N_SLOT*LEN_W | Register length per slot, slot 0 in the low field |
| inst_acc_i | input | N_SLOT*ACC_W | Access count per slot, slot 0 in the low field |
| scan_en_o | output | 1 | Shift enable toward the network |
| scan_do_o | output | 1 | Serial bit into the network |
| update_o | output | 1 | Update strobe |
| capture_o | output | 1 | Capture strobe |
| seg_open_o | output | N_SLOT | Open state of each cell |
| path_len_o | output | PATH_W | Current scan-path length in bits |
| done_o | output | 1 | One-cycle completion pulse |
| cyc_total_o | output | CNT_W | Overall access time in cycles |
| cyc_data_o | output | CNT_W | Cycles that shifted instrument data |
| cyc_ctrl_o | output | CNT_W | Cycles that shifted cell control bits |
| cyc_cuc_o | output | CNT_W | Update/capture gap cycles |

## Verification
The bound checker watches several properties on every cycle:
- the strobes are mutually exclusive and spaced correctly;
- each shift phase length matches the reported path length;
- cell states change only after an update;
- the counter sum is consistent;
- done is a single pulse.

Some behaviour can only be shown by the bench's scenarios, because it needs a model of the schedule:
- the exact bit stream, meaning the control-bit values, the data numbering and the zero unload data;
- the number of scans each slot stays open;
- the absolute counter totals;
- start being ignored in mid-run.

// File: rtl/sib_seq_pkg.sv
package sib_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_CUC,
      ST_DONE
   } seq_state_t;

   // Length of the update/capture gap and the positions of its strobes.
   localparam int unsigned CUC_CYCLES = 5;
   localparam int unsigned UPD_POS    = 1;
   localparam int unsigned CAP_POS    = 3;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sib_slot_ctrl.sv
// One cell: open state, scans remaining, next control bit, data word.
module sib_slot_ctrl #(
   parameter int unsigned ACC_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             first_i,
   input  logic             upd_i,
   input  logic [ACC_W-1:0] acc_i,
   output logic             open_o,
   output logic             ctrl_bit_o,
   output logic [ACC_W:0]   data_word_o
);
   localparam int unsigned KW = ACC_W + 1;
   localparam int unsigned XW = KW + 1;

   logic [KW-1:0] rem_q;
   logic          open_q;
   logic [KW-1:0] acc_ext;
   logic          has_work;
   logic          more;
   logic [XW-1:0] idx_wide;

   assign acc_ext  = KW'(acc_i);
   assign has_work = (acc_i != '0);
   assign more     = open_q && (rem_q > KW'(1));

   assign ctrl_bit_o = first_i ? has_work : more;

   // Access number k = A + 2 - remaining while inputs are still pending.
   assign idx_wide    = {1'b0, acc_ext} + XW'(2) - {1'b0, rem_q};
   assign data_word_o = more ? idx_wide[KW-1:0] : '0;
   assign open_o      = open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         rem_q  <= '0;
      end else if (upd_i) begin
         open_q <= ctrl_bit_o;
         if (first_i)
            rem_q <= has_work ? acc_ext + KW'(1) : '0;
         else if (open_q)
            rem_q <= rem_q - KW'(1);
      end
   end
endmodule

// File: rtl/sib_path_len.sv
// Scan-path length: one bit per cell plus every open instrument register.
module sib_path_len #(
   parameter int unsigned N_SLOT = 3,
   parameter int unsigned LEN_W  = 8,
   parameter int unsigned PATH_W = 11
)(
   input  logic [N_SLOT-1:0]       open_i,
   input  logic [N_SLOT*LEN_W-1:0] len_i,
   output logic [PATH_W-1:0]       path_len_o
);
   always_comb begin
      path_len_o = PATH_W'(N_SLOT);
      for (int i = 0; i < int'(N_SLOT); i++) begin
         if (open_i[i])
            path_len_o = path_len_o + PATH_W'(len_i[i*LEN_W +: LEN_W]);
      end
   end
endmodule

// File: rtl/sib_shift_ptr.sv
// Walks the path from the scan-out end: cell bit, then its data segment.
module sib_shift_ptr #(
   parameter int unsigned N_SLOT = 3,
   parameter int unsigned LEN_W  = 8,
   parameter int unsigned KW     = 9,
   parameter int unsigned SW     = 2
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_i,
   input  logic                    step_i,
   input  logic [N_SLOT-1:0]       open_i,
   input  logic [N_SLOT-1:0]       ctrl_i,
   input  logic [N_SLOT*LEN_W-1:0] len_i,
   input  logic [N_SLOT*KW-1:0]    data_i,
   output logic                    bit_o,
   output logic                    in_data_o,
   output logic                    last_o
);
   logic [LEN_W-1:0] len_a [N_SLOT];
   logic [KW-1:0]    dat_a [N_SLOT];

   for (genvar g = 0; g < int'(N_SLOT); g++) begin : g_unpack
      assign len_a[g] = len_i[g*LEN_W +: LEN_W];
      assign dat_a[g] = data_i[g*KW +: KW];
   end

   logic [SW-1:0]    slot_q;
   logic             in_data_q;
   logic [LEN_W-1:0] bidx_q;
   logic [LEN_W-1:0] cur_len;
   logic [KW-1:0]    cur_word;
   logic             go_data;
   logic             seg_end;

   always_comb begin
      cur_len  = len_a[slot_q];
      cur_word = dat_a[slot_q] >> bidx_q;
      go_data  = !in_data_q && open_i[slot_q] && (cur_len != '0);
      seg_end  = in_data_q && (bidx_q == cur_len - LEN_W'(1));
      last_o   = (slot_q == '0) && ((!in_data_q && !go_data) || seg_end);
      bit_o    = in_data_q ? cur_word[0] : ctrl_i[slot_q];
   end

   assign in_data_o = in_data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q    <= '0;
         in_data_q <= 1'b0;
         bidx_q    <= '0;
      end else if (load_i) begin
         slot_q    <= SW'(N_SLOT - 1);
         in_data_q <= 1'b0;
         bidx_q    <= '0;
      end else if (step_i) begin
         if (!in_data_q) begin
            if (go_data) begin
               in_data_q <= 1'b1;
               bidx_q    <= '0;
            end else begin
               slot_q <= slot_q - SW'(1);
            end
         end else if (seg_end) begin
            in_data_q <= 1'b0;
            slot_q    <= slot_q - SW'(1);
         end else begin
            bidx_q <= bidx_q + LEN_W'(1);
         end
      end
   end
endmodule

// File: rtl/sib_stat_cnt.sv
// Access-time accounting split by cycle kind.
module sib_stat_cnt #(
   parameter int unsigned CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             shift_i,
   input  logic             in_data_i,
   input  logic             cuc_i,
   output logic [CNT_W-1:0] total_o,
   output logic [CNT_W-1:0] data_o,
   output logic [CNT_W-1:0] ctrl_o,
   output logic [CNT_W-1:0] cuc_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         total_o <= '0;
         data_o  <= '0;
         ctrl_o  <= '0;
         cuc_o   <= '0;
      end else if (clr_i) begin
         total_o <= '0;
         data_o  <= '0;
         ctrl_o  <= '0;
         cuc_o   <= '0;
      end else begin
         if (shift_i || cuc_i)      total_o <= total_o + CNT_W'(1);
         if (shift_i && in_data_i)  data_o  <= data_o + CNT_W'(1);
         if (shift_i && !in_data_i) ctrl_o  <= ctrl_o + CNT_W'(1);
         if (cuc_i)                 cuc_o   <= cuc_o + CNT_W'(1);
      end
   end
endmodule

// File: rtl/sib_scan_sequencer.sv
module sib_scan_sequencer
   import sib_seq_pkg::*;
#(
   parameter int unsigned N_SLOT = 3,
   parameter int unsigned LEN_W  = 8,
   parameter int unsigned ACC_W  = 8,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PATH_W = $clog2(N_SLOT * (2 ** LEN_W) + 1) + 1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [N_SLOT*LEN_W-1:0] inst_len_i,
   input  logic [N_SLOT*ACC_W-1:0] inst_acc_i,
   output logic                    scan_en_o,
   output logic                    scan_do_o,
   output logic                    update_o,
   output logic                    capture_o,
   output logic [N_SLOT-1:0]       seg_open_o,
   output logic [PATH_W-1:0]       path_len_o,
   output logic                    done_o,
   output logic [CNT_W-1:0]        cyc_total_o,
   output logic [CNT_W-1:0]        cyc_data_o,
   output logic [CNT_W-1:0]        cyc_ctrl_o,
   output logic [CNT_W-1:0]        cyc_cuc_o
);
   localparam int unsigned KW    = ACC_W + 1;
   localparam int unsigned SW    = idx_w(N_SLOT);
   localparam int unsigned GAP_W = 3;

   // Elaboration-time parameter checks
   if (N_SLOT < 1)        $error("N_SLOT must be at least 1");
   if (LEN_W < 1)         $error("LEN_W must be at least 1");
   if (ACC_W < 1)         $error("ACC_W must be at least 1");
   if (CNT_W < 4)         $error("CNT_W too narrow");
   if ((2 ** PATH_W) <= N_SLOT * (2 ** LEN_W))
                          $error("PATH_W cannot hold the longest path");
   if (CUC_CYCLES > (2 ** GAP_W) || CAP_POS >= CUC_CYCLES)
                          $error("gap length does not fit its counter");

   seq_state_t        state_q;
   logic [GAP_W-1:0]  gap_q;
   logic              first_q;

   logic [N_SLOT-1:0]    seg_open;
   logic [N_SLOT-1:0]    ctrl_bits;
   logic [N_SLOT*KW-1:0] data_words;
   logic                 upd_pulse;
   logic                 cap_pulse;
   logic                 gap_end;
   logic                 ptr_load;
   logic                 ptr_bit;
   logic                 ptr_in_data;
   logic                 ptr_last;
   logic                 in_shift;
   logic                 in_gap;

   assign in_shift  = (state_q == ST_SHIFT);
   assign in_gap    = (state_q == ST_CUC);
   assign upd_pulse = in_gap && (gap_q == GAP_W'(UPD_POS));
   assign cap_pulse = in_gap && (gap_q == GAP_W'(CAP_POS));
   assign gap_end   = in_gap && (gap_q == GAP_W'(CUC_CYCLES - 1));
   assign ptr_load  = ((state_q == ST_IDLE) && start_i) || (gap_end && (|seg_open));

   for (genvar g = 0; g < int'(N_SLOT); g++) begin : g_slot
      sib_slot_ctrl #(.ACC_W(ACC_W)) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .first_i     (first_q),
         .upd_i       (upd_pulse),
         .acc_i       (inst_acc_i[g*ACC_W +: ACC_W]),
         .open_o      (seg_open[g]),
         .ctrl_bit_o  (ctrl_bits[g]),
         .data_word_o (data_words[g*KW +: KW])
      );
   end

   sib_path_len #(.N_SLOT(N_SLOT), .LEN_W(LEN_W), .PATH_W(PATH_W)) u_len (
      .open_i     (seg_open),
      .len_i      (inst_len_i),
      .path_len_o (path_len_o)
   );

   sib_shift_ptr #(.N_SLOT(N_SLOT), .LEN_W(LEN_W), .KW(KW), .SW(SW)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (ptr_load),
      .step_i    (in_shift),
      .open_i    (seg_open),
      .ctrl_i    (ctrl_bits),
      .len_i     (inst_len_i),
      .data_i    (data_words),
      .bit_o     (ptr_bit),
      .in_data_o (ptr_in_data),
      .last_o    (ptr_last)
   );

   sib_stat_cnt #(.CNT_W(CNT_W)) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     ((state_q == ST_IDLE) && start_i),
      .shift_i   (in_shift),
      .in_data_i (ptr_in_data),
      .cuc_i     (in_gap),
      .total_o   (cyc_total_o),
      .data_o    (cyc_data_o),
      .ctrl_o    (cyc_ctrl_o),
      .cuc_o     (cyc_cuc_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         gap_q   <= '0;
         first_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_SHIFT;
                  first_q <= 1'b1;
               end
            end
            ST_SHIFT: begin
               if (ptr_last) begin
                  state_q <= ST_CUC;
                  gap_q   <= '0;
               end
            end
            ST_CUC: begin
               gap_q <= gap_q + GAP_W'(1);
               if (upd_pulse) first_q <= 1'b0;
               if (gap_end) state_q <= (|seg_open) ? ST_SHIFT : ST_DONE;
            end
            ST_DONE:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign scan_en_o  = in_shift;
   assign scan_do_o  = in_shift && ptr_bit;
   assign update_o   = upd_pulse;
   assign capture_o  = cap_pulse;
   assign seg_open_o = seg_open;
   assign done_o     = (state_q == ST_DONE);

endmodule

// File: rtl/sib_scan_sequencer_chk.sv
module sib_scan_sequencer_chk #(
   parameter int unsigned N_SLOT = 3,
   parameter int unsigned LEN_W  = 8,
   parameter int unsigned ACC_W  = 8,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PATH_W = 11
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start_i,
   input logic [N_SLOT*LEN_W-1:0] inst_len_i,
   input logic [N_SLOT*ACC_W-1:0] inst_acc_i,
   input logic                    scan_en_o,
   input logic                    scan_do_o,
   input logic                    update_o,
   input logic                    capture_o,
   input logic [N_SLOT-1:0]       seg_open_o,
   input logic [PATH_W-1:0]       path_len_o,
   input logic                    done_o,
   input logic [CNT_W-1:0]        cyc_total_o,
   input logic [CNT_W-1:0]        cyc_data_o,
   input logic [CNT_W-1:0]        cyc_ctrl_o,
   input logic [CNT_W-1:0]        cyc_cuc_o
);
   logic [PATH_W-1:0] shift_run;
   logic              unused_ok;

   assign unused_ok = ^{start_i, inst_len_i, inst_acc_i, scan_do_o};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         shift_run <= '0;
      else if (scan_en_o) shift_run <= shift_run + PATH_W'(1);
      else                shift_run <= '0;
   end

   assert_strobe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({scan_en_o, update_o, capture_o, done_o}));

   assert_update_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      update_o |=> (!scan_en_o && !update_o && !capture_o));

   assert_capture_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      capture_o |-> $past(update_o, 2));

   assert_open_changes_at_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(update_o) |-> $stable(seg_open_o));

   assert_shift_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_en_o && shift_run != '0) |-> (shift_run == path_len_o));

   assert_counter_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_total_o == CNT_W'(cyc_data_o + cyc_ctrl_o + cyc_cuc_o));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_all_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (seg_open_o == '0));

endmodule

bind sib_scan_sequencer sib_scan_sequencer_chk #(
   .N_SLOT(N_SLOT), .LEN_W(LEN_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .PATH_W(PATH_W)
) u_chk (.*);

// File: tb/sib_scan_sequencer_tb.sv
module sib_scan_sequencer_tb;
   localparam int N  = 3;
   localparam int LW = 4;
   localparam int AW = 4;
   localparam int CW = 16;
   localparam int PW = $clog2(N * (2 ** LW) + 1) + 1;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           start;
   logic [N*LW-1:0] len_bus;
   logic [N*AW-1:0] acc_bus;
   logic           scan_en, scan_do, upd, cap, done;
   logic [N-1:0]   seg_open;
   logic [PW-1:0]  path_len;
   logic [CW-1:0]  c_tot, c_dat, c_ctl, c_cuc;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   sib_scan_sequencer #(.N_SLOT(N), .LEN_W(LW), .ACC_W(AW), .CNT_W(CW), .PATH_W(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .inst_len_i(len_bus), .inst_acc_i(acc_bus),
      .scan_en_o(scan_en), .scan_do_o(scan_do), .update_o(upd), .capture_o(cap),
      .seg_open_o(seg_open), .path_len_o(path_len), .done_o(done),
      .cyc_total_o(c_tot), .cyc_data_o(c_dat), .cyc_ctrl_o(c_ctl), .cyc_cuc_o(c_cuc)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic shift_cycle(input int exp_bit, input int plen, input string tag, input bit poke);
      chk(tag, {scan_en, scan_do}, {1'b1, exp_bit[0]});
      chk("R3 path length during shift", path_len, plen);
      start = poke;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_case(input int l0, input int l1, input int l2,
                           input int a0, input int a1, input int a2,
                           input bit poke, input bit doc);
      int  L[N];
      int  A[N];
      int  rem[N];
      bit  opn[N];
      bit  nopen[N];
      bit  first;
      int  plen, kv, scan, ov, nv;
      int  etot, edat, ectl, ecuc;
      bit  any;
      L[0] = l0; L[1] = l1; L[2] = l2;
      A[0] = a0; A[1] = a1; A[2] = a2;
      for (int s = 0; s < N; s++) begin rem[s] = 0; opn[s] = 0; nopen[s] = 0; end
      first = 1; scan = 0; etot = 0; edat = 0; ectl = 0; ecuc = 0;
      len_bus = {LW'(l2), LW'(l1), LW'(l0)};
      acc_bus = {AW'(a2), AW'(a1), AW'(a0)};
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R11 counters cleared by start", c_tot, 0);
      while (1) begin
         plen = N;
         for (int s = 0; s < N; s++) if (opn[s]) plen += L[s];
         for (int s = N - 1; s >= 0; s--) begin
            nopen[s] = first ? (A[s] != 0) : (opn[s] && rem[s] > 1);
            shift_cycle(int'(nopen[s]), plen, first ? "R2 opening control bit" : "R4 R6 control bit",
                        poke && scan == 2 && s == N - 1);
            ectl++;
            if (opn[s]) begin
               for (int j = 0; j < L[s]; j++) begin
                  kv = (rem[s] > 1) ? (A[s] + 2 - rem[s]) : 0;
                  shift_cycle((kv >> j) & 1, plen, "R5 data bit", 1'b0);
                  edat++;
               end
            end
         end
         ov = 0; nv = 0;
         for (int s = 0; s < N; s++) begin
            ov |= int'(opn[s]) << s;
            nv |= int'(nopen[s]) << s;
         end
         for (int c = 0; c < 5; c++) begin
            chk("R7 gap strobes", {scan_en, upd, cap, done},
                {1'b0, c == 1, c == 3, 1'b0});
            chk("R6 cell state around update", seg_open, (c >= 2) ? nv : ov);
            @(negedge clk);
            ecuc++;
         end
         any = 0;
         for (int s = 0; s < N; s++) begin
            if (first) rem[s] = (A[s] != 0) ? A[s] + 1 : 0;
            else if (opn[s]) rem[s] = rem[s] - 1;
            opn[s] = nopen[s];
            any |= opn[s];
         end
         first = 0;
         etot += plen + 5;
         scan++;
         if (!any || scan > 40) break;
      end
      chk("R8 done after final gap", done, 1);
      chk("R9 total cycles", c_tot, etot);
      chk("R9 data cycles", c_dat, edat);
      chk("R9 control cycles", c_ctl, ectl);
      chk("R9 gap cycles", c_cuc, ecuc);
      if (doc) begin
         chk(poke ? "R10 total unaffected by start" : "R9 total 183", c_tot, 183);
         chk("R9 data 87", c_dat, 87);
         chk("R9 control 36", c_ctl, 36);
         chk("R9 gap 60", c_cuc, 60);
      end
      @(negedge clk);
      chk("R8 done single cycle", {done, scan_en}, 0);
      chk("R6 all closed after run", seg_open, 0);
      @(negedge clk);
      chk("R11 total held after done", c_tot, etot);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R8 actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      len_bus = '0;
      acc_bus = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset strobes", {scan_en, scan_do, upd, cap, done}, 0);
      chk("R1 reset cells closed", seg_open, 0);
      chk("R1 reset path length", path_len, N);
      chk("R1 reset counters", {c_tot, c_dat, c_ctl, c_cuc}, 0);

      run_case(3, 5, 4, 5, 4, 10, 1'b0, 1'b1);
      run_case(3, 5, 4, 5, 4, 10, 1'b1, 1'b1);   // R10: start pulsed mid-run

      for (int l0 = 1; l0 <= 3; l0++)
         for (int l1 = 1; l1 <= 3; l1++)
            for (int l2 = 1; l2 <= 3; l2++)
               for (int a0 = 0; a0 <= 2; a0++)
                  for (int a1 = 0; a1 <= 2; a1++)
                     for (int a2 = 0; a2 <= 2; a2++)
                        run_case(l0, l1, l2, a0, a1, a2, 1'b0, 1'b0);

      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule